// File: doc/BRIEF.md
# Descriptor fetch skip controller

This block sits ahead of the descriptor-fetch engine of a transfer controller. For every transfer request it accepts, it decides whether the engine has to read the vector entry and transfer descriptor from memory again, or whether the descriptor already held inside the controller can be reused. Reuse saves the memory reads when the same requester triggers several transfers in a row.

The block keeps one stored vector number and a flag that marks it valid. A request may reuse the held descriptor only when four conditions are all true: software has set the skip-enable input, the stored number is valid, the stored number equals the request's vector, and the status of the previous transfer does not force a reload. The previous transfer forces a reload if it was part of a chain. It also forces one if its counter ran out in normal or block mode. A counter that runs out in repeat mode does not force a reload, because that counter reloads itself.

The decision is registered. It appears one clock after the request, together with a strobe that marks it. Software clears the skip-enable input before it rewrites descriptors in memory. Doing so discards the stored vector number, so the next request always fetches.

Top module: `desc_skip_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `dec_valid`, `fetch_req` and `held_valid` are 0 and `held_vec` is 0.
- R2: `dec_valid` is 1 in the cycle after each cycle in which `req_valid` is 1, and 0 otherwise. `fetch_req` is 0 whenever `dec_valid` is 0.
- R3: A request whose vector equals a valid `held_vec` gives `fetch_req` 0 when `skip_en` is 1, `prev_chain` is 0, and the previous status is not an exhausted normal or block transfer. `held_vec` is then left unchanged.
- R4: A request whose vector differs from `held_vec` gives `fetch_req` 1. In the same cycle `held_vec` takes the request's vector.
- R5: A request with `prev_chain` at 1 gives `fetch_req` 1, whatever the vector comparison says.
- R6: A request with `prev_mode` = 2'b00 (normal) and `prev_cnt_zero` at 1 gives `fetch_req` 1, even when the vector matches.
- R7: A request with `prev_mode` = 2'b10 (block) and `prev_cnt_zero` at 1 gives `fetch_req` 1, even when the vector matches.
- R8: A request with `prev_mode` = 2'b01 (repeat) and `prev_cnt_zero` at 1 does not force a fetch on its own. A matching valid vector with `skip_en` at 1 still gives `fetch_req` 0.
- R9: While `skip_en` is 0, `held_valid` is 0 one cycle later and every request gives `fetch_req` 1. After `skip_en` returns to 1, the first request fetches even if its vector equals `held_vec`.
- R10: When `held_valid` is 0, a request gives `fetch_req` 1. If `skip_en` is 1, that fetch sets `held_valid` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | A transfer request is accepted in this cycle |
| req_vec | input | VEC_W | Vector number of the accepted request |
| skip_en | input | 1 | Software enable for skipping the descriptor reload |
| prev_chain | input | 1 | The previous transfer was part of a chain |
| prev_mode | input | 2 | Mode of the previous transfer: 00 normal, 01 repeat, 10 block |
| prev_cnt_zero | input | 1 | The counter of the previous transfer reached zero |
| dec_valid | output | 1 | A fetch decision is presented in this cycle |
| fetch_req | output | 1 | The vector and descriptor must be fetched from memory |
| held_vec | output | VEC_W | Stored vector number of the last fetch |
| held_valid | output | 1 | The stored vector number may be used for reuse |

## Verification
The outputs `dec_valid`, `fetch_req`, `held_vec` and `held_valid` are all due at the first rising edge after the request is sampled. Clearing `skip_en` drops `held_valid` at the next edge. Each scenario task drives its inputs on a falling edge and lets one rising edge pass. It compares all four outputs on the following falling edge, so the bench never samples at the edge where they change. One idle cycle after a request checks that the strobe and the decision go back to 0.

// File: rtl/dskip_pkg.sv
package dskip_pkg;

  typedef enum logic [1:0] {
    XMODE_NORMAL = 2'b00,
    XMODE_REPEAT = 2'b01,
    XMODE_BLOCK  = 2'b10,
    XMODE_RSVD   = 2'b11
  } xfer_mode_e;

  // One bit per mode code: 1 when exhaustion of that mode's counter
  // invalidates the held descriptor. Repeat mode reloads its counter.
  function automatic logic [3:0] exhaust_mask();
    logic [3:0] m;
    m = '0;
    m[XMODE_NORMAL] = 1'b1;
    m[XMODE_BLOCK]  = 1'b1;
    m[XMODE_RSVD]   = 1'b1;
    return m;
  endfunction

endpackage

// File: rtl/dskip_override.sv
module dskip_override
  import dskip_pkg::*;
#(
  parameter logic [3:0] EXH_MASK = exhaust_mask()
) (
  input  logic       prev_chain,
  input  logic [1:0] prev_mode,
  input  logic       prev_cnt_zero,
  output logic       force_fetch
);

  logic exhausted;

  always_comb begin
    exhausted   = prev_cnt_zero & EXH_MASK[prev_mode];
    force_fetch = prev_chain | exhausted;
  end

endmodule

// File: rtl/dskip_vec_cmp.sv
module dskip_vec_cmp #(
  parameter int VEC_W = 8
) (
  input  logic [VEC_W-1:0] a,
  input  logic [VEC_W-1:0] b,
  output logic             equal
);

  logic [VEC_W-1:0] bit_eq;

  genvar gi;
  generate
    for (gi = 0; gi < VEC_W; gi++) begin : g_bit
      assign bit_eq[gi] = ~(a[gi] ^ b[gi]);
    end
  endgenerate

  assign equal = &bit_eq;

endmodule

// File: rtl/dskip_vec_hold.sv
module dskip_vec_hold #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             skip_en,
  input  logic             load_en,
  input  logic [VEC_W-1:0] load_vec,
  output logic [VEC_W-1:0] vec_q,
  output logic             valid_q
);

  logic [VEC_W-1:0] vec_d;
  logic             valid_d;

  always_comb begin
    vec_d   = vec_q;
    valid_d = valid_q;
    if (load_en) begin
      vec_d   = load_vec;
      valid_d = 1'b1;
    end
    if (!skip_en) begin
      valid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      vec_q   <= vec_d;
      valid_q <= valid_d;
    end
  end

endmodule

// File: rtl/desc_skip_ctrl.sv
module desc_skip_ctrl
  import dskip_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [VEC_W-1:0] req_vec,
  input  logic             skip_en,
  input  logic             prev_chain,
  input  logic [1:0]       prev_mode,
  input  logic             prev_cnt_zero,
  output logic             dec_valid,
  output logic             fetch_req,
  output logic [VEC_W-1:0] held_vec,
  output logic             held_valid
);

  logic vec_match;
  logic force_fetch;
  logic need_fetch;
  logic load_en;
  logic dec_valid_d;
  logic fetch_d;

  dskip_vec_cmp #(.VEC_W(VEC_W)) u_cmp (
    .a     (req_vec),
    .b     (held_vec),
    .equal (vec_match)
  );

  dskip_override u_ovr (
    .prev_chain    (prev_chain),
    .prev_mode     (prev_mode),
    .prev_cnt_zero (prev_cnt_zero),
    .force_fetch   (force_fetch)
  );

  always_comb begin
    need_fetch  = ~skip_en | ~held_valid | ~vec_match | force_fetch;
    load_en     = req_valid & need_fetch;
    dec_valid_d = req_valid;
    fetch_d     = req_valid & need_fetch;
  end

  dskip_vec_hold #(.VEC_W(VEC_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .skip_en  (skip_en),
    .load_en  (load_en),
    .load_vec (req_vec),
    .vec_q    (held_vec),
    .valid_q  (held_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_valid <= 1'b0;
      fetch_req <= 1'b0;
    end else begin
      dec_valid <= dec_valid_d;
      fetch_req <= fetch_d;
    end
  end

endmodule

// File: rtl/desc_skip_ctrl_chk.sv
module desc_skip_ctrl_chk #(
  parameter int VEC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [VEC_W-1:0] req_vec,
  input logic             skip_en,
  input logic             prev_chain,
  input logic             dec_valid,
  input logic             fetch_req,
  input logic [VEC_W-1:0] held_vec,
  input logic             held_valid
);

  // R2
  a_r2_strobe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> dec_valid);
  a_r2_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !dec_valid);
  a_r2_fetch_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !dec_valid |-> !fetch_req);
  // R3
  a_r3_skip_keeps_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && skip_en && held_valid && req_vec == held_vec && !prev_chain)
      |=> $stable(held_vec) || fetch_req);
  // R4
  a_r4_mismatch_loads: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_vec != held_vec) |=> fetch_req && held_vec == $past(req_vec));
  // R5
  a_r5_chain_forces: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && prev_chain) |=> fetch_req);
  // R9
  a_r9_disable_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !skip_en |=> !held_valid);
  // R10
  a_r10_invalid_fetches: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !held_valid) |=> fetch_req);

endmodule

bind desc_skip_ctrl desc_skip_ctrl_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_vec    (req_vec),
  .skip_en    (skip_en),
  .prev_chain (prev_chain),
  .dec_valid  (dec_valid),
  .fetch_req  (fetch_req),
  .held_vec   (held_vec),
  .held_valid (held_valid)
);

// File: tb/tb_desc_skip_ctrl.sv
`timescale 1ns/1ps
module tb_desc_skip_ctrl;

  localparam int VW = 8;

  logic          clk;
  logic          rst_n;
  logic          req_valid;
  logic [VW-1:0] req_vec;
  logic          skip_en;
  logic          prev_chain;
  logic [1:0]    prev_mode;
  logic          prev_cnt_zero;
  logic          dec_valid;
  logic          fetch_req;
  logic [VW-1:0] held_vec;
  logic          held_valid;

  int n_chk;
  int n_bad;

  desc_skip_ctrl #(.VEC_W(VW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vec(req_vec),
    .skip_en(skip_en), .prev_chain(prev_chain), .prev_mode(prev_mode),
    .prev_cnt_zero(prev_cnt_zero), .dec_valid(dec_valid), .fetch_req(fetch_req),
    .held_vec(held_vec), .held_valid(held_valid)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // One request; all outputs checked on the falling edge after the next rising edge.
  task automatic do_req(string tag, logic [VW-1:0] v, logic ch, logic [1:0] md,
                        logic cz, int exp_fetch, int exp_vec, int exp_valid);
    @(negedge clk);
    req_valid = 1'b1; req_vec = v; prev_chain = ch; prev_mode = md; prev_cnt_zero = cz;
    @(negedge clk);
    req_valid = 1'b0; prev_chain = 1'b0; prev_cnt_zero = 1'b0; prev_mode = 2'b00;
    check(tag, "dec_valid", int'(dec_valid), 1);
    check(tag, "fetch_req", int'(fetch_req), exp_fetch);
    check(tag, "held_vec", int'(held_vec), exp_vec);
    check(tag, "held_valid", int'(held_valid), exp_valid);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_vec = '0; skip_en = 1'b0;
    prev_chain = 1'b0; prev_mode = 2'b00; prev_cnt_zero = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "dec_valid", int'(dec_valid), 0);
    check("R1", "fetch_req", int'(fetch_req), 0);
    check("R1", "held_valid", int'(held_valid), 0);
    check("R1", "held_vec", int'(held_vec), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "held_valid after release", int'(held_valid), 0);
  endtask

  task automatic t_first_fetch();
    skip_en = 1'b1;
    do_req("R10", 8'd5, 1'b0, 2'b00, 1'b0, 1, 5, 1);
  endtask

  task automatic t_skip_hit();
    do_req("R3", 8'd5, 1'b0, 2'b00, 1'b0, 0, 5, 1);
  endtask

  task automatic t_mismatch();
    do_req("R4", 8'd9, 1'b0, 2'b00, 1'b0, 1, 9, 1);
    do_req("R4", 8'hA6, 1'b0, 2'b01, 1'b0, 1, 166, 1);
    do_req("R4", 8'd9, 1'b0, 2'b00, 1'b0, 1, 9, 1);
  endtask

  task automatic t_chain();
    do_req("R5", 8'd9, 1'b1, 2'b00, 1'b0, 1, 9, 1);
  endtask

  task automatic t_normal_zero();
    do_req("R6", 8'd9, 1'b0, 2'b00, 1'b1, 1, 9, 1);
  endtask

  task automatic t_block_zero();
    do_req("R7", 8'd9, 1'b0, 2'b10, 1'b1, 1, 9, 1);
    do_req("R3", 8'd9, 1'b0, 2'b10, 1'b0, 0, 9, 1);
  endtask

  task automatic t_repeat_zero();
    do_req("R8", 8'd9, 1'b0, 2'b01, 1'b1, 0, 9, 1);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R2", "dec_valid idle", int'(dec_valid), 0);
    check("R2", "fetch_req idle", int'(fetch_req), 0);
  endtask

  task automatic t_disable();
    @(negedge clk);
    skip_en = 1'b0;
    @(negedge clk);
    check("R9", "held_valid after clear", int'(held_valid), 0);
    do_req("R9", 8'd9, 1'b0, 2'b01, 1'b0, 1, 9, 0);
    skip_en = 1'b1;
    do_req("R9", 8'd9, 1'b0, 2'b01, 1'b0, 1, 9, 1);
    do_req("R3", 8'd9, 1'b0, 2'b01, 1'b0, 0, 9, 1);
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    t_reset();
    t_first_fetch();
    t_skip_hit();
    t_mismatch();
    t_chain();
    t_normal_zero();
    t_block_zero();
    t_repeat_zero();
    t_idle();
    t_disable();
    t_idle();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule